// File: doc/BRIEF.md
# IR Run-Length Receive Sampler

The sampler watches an already demodulated infrared receiver line and describes what it sees as a stream of bytes. A programmable prescaler produces a sample tick (nominally every 10 us). Every stretch of constant level is measured in ticks. When the level changes, the stretch is written into a 16-entry receive FIFO as one byte. Bit 7 of the byte gives the level and bits 6:0 give the length minus one. A stretch longer than the 7-bit field can hold is cut into several bytes of the same level.

A host reaches the block through a small register port. Reading the data offset pops the oldest byte. A line status register reports whether data is waiting and whether a byte was lost. An identification register and an enable register with the same bit layout drive a single interrupt line. The host can invert the receiver polarity. It can also order the receiver back to idle, where it waits for the next edge before it measures again.

Top module: `ir_rl_sampler`

## Requirements
- R1: The line is sampled once every TICK_DIV clocks. After inversion, a sampled 1 is a pulse and a 0 is a space. A finished run of n ticks (1 <= n <= 128) is stored as one byte. Bit 7 of that byte is 1 for a space and 0 for a pulse, and bits 6:0 hold n-1.
- R2: A run of more than 128 ticks first emits one byte with bits 6:0 = 0x7F for every 128 ticks completed before the last partial group. This gives 0x7F for a pulse and 0xFF for a space. The remainder is then coded as in R1. A run of 128 ticks gives 0x7F, a run of 129 gives 0x7F then 0x00, and a space of 257 gives 0xFF, 0xFF, 0x80.
- R3: After reset, or after being forced idle, the receiver stores no byte for the level it finds. Its first run starts at the first level change. A run still in progress is not stored until the level changes again.
- R4: When invertEn is 1, the input polarity is flipped before sampling. A high irIn is then coded as a space.
- R5: Writing a 1 to bit 5 at offset 4 forces the receiver idle. The run in progress is discarded without a byte, and the bytes already in the FIFO are kept.
- R6: The FIFO holds 16 bytes. A read at offset 0 returns the oldest byte and removes it. A read at offset 0 on an empty FIFO returns 0x00 and changes nothing.
- R7: Line status at offset 3 has bit 0 set whenever the FIFO holds at least one byte.
- R8: A byte produced while the FIFO is full is dropped and the FIFO contents stay unchanged. The drop sets line status bit 1, which stays set until offset 3 is read. A read clears it unless another drop happens in the same cycle.
- R9: Identification at offset 2 shows bit 0 when the FIFO holds 8 or more bytes and bit 2 while line status bit 1 is set. Offset 1 is read/write, and only its bits 0 and 2 are implemented. irq is high when a bit is set in both registers.
- R10: After reset the FIFO is empty, the status, identification and enable registers read 0x00, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irIn | input | 1 | Demodulated receiver line, asynchronous |
| invertEn | input | 1 | Flip input polarity before sampling |
| regAddr | input | 3 | Register offset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe; side effects at the clock edge |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, valid in the cycle regRd is high |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the run boundaries 1, 128, 129 and 257 ticks. A counter that wraps instead of splitting would report 129 ticks as a 1-tick run. Off-by-one splitting would show up as a stray 0x00 or a missing 0x7F. A force-idle in the middle of a run checks that a sloppy design neither leaks the half-measured run nor clears the FIFO. Pushing 19 bytes into the 16-entry FIFO checks that the overrun keeps the oldest data and raises a sticky flag that one status read clears. A design that overwrote data or cleared the flag early would fail this. The bench also steps the FIFO level across the threshold of 8 to catch a comparison that is off by one.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;

  localparam int CODE_W   = 8;
  localparam int LEN_W    = CODE_W - 1;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_IID   = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_LSTAT = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_AUX   = 3'd4;

  localparam int BIT_EV_RX    = 0;
  localparam int BIT_EV_ERR   = 2;
  localparam int BIT_LS_AVAIL = 0;
  localparam int BIT_LS_OVR   = 1;
  localparam int BIT_AUX_IDLE = 5;

  typedef enum logic [1:0] {
    RX_WAIT_REF,
    RX_WAIT_EDGE,
    RX_RUN
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic popReq;
    logic forceIdle;
  } dpCtrl_t;

  // events from datapath to control
  typedef struct packed {
    logic pushed;
    logic dropped;
  } dpEvt_t;

endpackage

// File: rtl/ir_rl_fifo.sv
module ir_rl_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 pushData,
  input  logic                         pop,
  output logic [W-1:0]                 popData,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + CNT_ONE;
        2'b01:   count <= count - CNT_ONE;
        default: count <= count;
      endcase
    end
  end

  assign popData = mem[rdPtr];

endmodule

// File: rtl/ir_rl_datapath.sv
module ir_rl_datapath
  import ir_rl_pkg::*;
#(
  parameter int TICK_DIV    = 240,
  parameter int SYNC_STAGES = 2,
  parameter int DEPTH       = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         irIn,
  input  logic                         invertEn,
  input  dpCtrl_t                      ctrl,
  output logic [CODE_W-1:0]            headByte,
  output logic [$clog2(DEPTH+1)-1:0]   fifoCount,
  output dpEvt_t                       evt
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
  localparam logic [LEN_W-1:0] RUN_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  // tick prescaler
  logic [DIV_W-1:0] divCnt;
  logic             tick;
  assign tick = (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  // polarity select ahead of the synchronizer keeps the sampled level glitch free
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ <= '0;
    end else begin
      syncQ[0] <= irIn ^ invertEn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end
  assign level = syncQ[SYNC_STAGES-1];

  // run measurement
  rxState_t          state;
  logic              refLevel;
  logic              runLevel;
  logic [LEN_W-1:0]  runCnt;
  logic              emitValid;
  logic [CODE_W-1:0] emitCode;

  always_comb begin
    emitValid = 1'b0;
    emitCode  = '0;
    if (tick && !ctrl.forceIdle && state == RX_RUN) begin
      if (level != runLevel) begin
        emitValid = 1'b1;
        emitCode  = {~runLevel, runCnt};
      end else if (runCnt == RUN_MAX) begin
        emitValid = 1'b1;
        emitCode  = {~runLevel, RUN_MAX};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_WAIT_REF;
      refLevel <= 1'b0;
      runLevel <= 1'b0;
      runCnt   <= '0;
    end else if (ctrl.forceIdle) begin
      state  <= RX_WAIT_REF;
      runCnt <= '0;
    end else if (tick) begin
      unique case (state)
        RX_WAIT_REF: begin
          refLevel <= level;
          state    <= RX_WAIT_EDGE;
        end
        RX_WAIT_EDGE: begin
          if (level != refLevel) begin
            state    <= RX_RUN;
            runLevel <= level;
            runCnt   <= '0;
          end
        end
        RX_RUN: begin
          if (level != runLevel) begin
            runLevel <= level;
            runCnt   <= '0;
          end else if (runCnt == RUN_MAX) begin
            runCnt <= '0;
          end else begin
            runCnt <= runCnt + 1'b1;
          end
        end
        default: state <= RX_WAIT_REF;
      endcase
    end
  end

  // receive FIFO
  logic fifoFull, fifoEmpty, doPush, doPop;
  assign fifoFull  = (fifoCount == CNT_FULL);
  assign fifoEmpty = (fifoCount == '0);
  assign doPush    = emitValid && !fifoFull;
  assign doPop     = ctrl.popReq && !fifoEmpty;

  ir_rl_fifo #(.W(CODE_W), .DEPTH(DEPTH)) uFifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (doPush),
    .pushData (emitCode),
    .pop      (doPop),
    .popData  (headByte),
    .count    (fifoCount)
  );

  assign evt.pushed  = doPush;
  assign evt.dropped = emitValid && fifoFull;

endmodule

// File: rtl/ir_rl_control.sv
module ir_rl_control
  import ir_rl_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int THRESH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic                         regWr,
  input  logic                         regRd,
  input  logic [CODE_W-1:0]            regWdata,
  input  logic [CODE_W-1:0]            headByte,
  input  logic [$clog2(DEPTH+1)-1:0]   fifoCount,
  input  dpEvt_t                       evt,
  output dpCtrl_t                      ctrl,
  output logic [CODE_W-1:0]            regRdata,
  output logic                         ovrPend,
  output logic                         irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_THR = CNT_W'(THRESH);

  logic ienRx, ienErr;
  logic evRx;
  logic lsRead;
  logic [CODE_W-1:0] idByte, ienByte, lsByte;

  assign ctrl.popReq    = regRd && (regAddr == OFS_DATA);
  assign ctrl.forceIdle = regWr && (regAddr == OFS_AUX) && regWdata[BIT_AUX_IDLE];
  assign lsRead         = regRd && (regAddr == OFS_LSTAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ienRx  <= 1'b0;
      ienErr <= 1'b0;
    end else if (regWr && regAddr == OFS_IEN) begin
      ienRx  <= regWdata[BIT_EV_RX];
      ienErr <= regWdata[BIT_EV_ERR];
    end
  end

  // a drop in the same cycle as the clearing read wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ovrPend <= 1'b0;
    else if (evt.dropped) ovrPend <= 1'b1;
    else if (lsRead)      ovrPend <= 1'b0;
  end

  assign evRx = (fifoCount >= CNT_THR);

  always_comb begin
    idByte = '0;
    idByte[BIT_EV_RX]  = evRx;
    idByte[BIT_EV_ERR] = ovrPend;
    ienByte = '0;
    ienByte[BIT_EV_RX]  = ienRx;
    ienByte[BIT_EV_ERR] = ienErr;
    lsByte = '0;
    lsByte[BIT_LS_AVAIL] = (fifoCount != '0);
    lsByte[BIT_LS_OVR]   = ovrPend;
  end

  always_comb begin
    unique case (regAddr)
      OFS_DATA:  regRdata = (fifoCount != '0) ? headByte : '0;
      OFS_IEN:   regRdata = ienByte;
      OFS_IID:   regRdata = idByte;
      OFS_LSTAT: regRdata = lsByte;
      default:   regRdata = '0;
    endcase
  end

  assign irq = |(idByte & ienByte);

  logic unusedWdata;
  assign unusedWdata = &{1'b0, regWdata[7:6], regWdata[4:3], regWdata[1]};

endmodule

// File: rtl/ir_rl_sampler.sv
module ir_rl_sampler
  import ir_rl_pkg::*;
#(
  parameter int TICK_DIV    = 240,
  parameter int SYNC_STAGES = 2,
  parameter int FIFO_DEPTH  = 16,
  parameter int RX_THRESH   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irIn,
  input  logic        invertEn,
  input  logic [2:0]  regAddr,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  output logic        irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  dpCtrl_t           dpCtrl;
  dpEvt_t            dpEvt;
  logic [CODE_W-1:0] headByte;
  logic [CNT_W-1:0]  fifoCount;
  logic              ovrPend;

  ir_rl_datapath #(
    .TICK_DIV    (TICK_DIV),
    .SYNC_STAGES (SYNC_STAGES),
    .DEPTH       (FIFO_DEPTH)
  ) uDp (
    .clk       (clk),
    .rst_n     (rst_n),
    .irIn      (irIn),
    .invertEn  (invertEn),
    .ctrl      (dpCtrl),
    .headByte  (headByte),
    .fifoCount (fifoCount),
    .evt       (dpEvt)
  );

  ir_rl_control #(
    .DEPTH  (FIFO_DEPTH),
    .THRESH (RX_THRESH)
  ) uCtl (
    .clk       (clk),
    .rst_n     (rst_n),
    .regAddr   (regAddr),
    .regWr     (regWr),
    .regRd     (regRd),
    .regWdata  (regWdata),
    .headByte  (headByte),
    .fifoCount (fifoCount),
    .evt       (dpEvt),
    .ctrl      (dpCtrl),
    .regRdata  (regRdata),
    .ovrPend   (ovrPend),
    .irq       (irq)
  );

endmodule

// File: rtl/ir_rl_checker.sv
module ir_rl_checker
  import ir_rl_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int THRESH = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           regAddr,
  input logic                        regWr,
  input logic                        regRd,
  input logic [CODE_W-1:0]           regWdata,
  input logic                        irq,
  input logic [$clog2(DEPTH+1)-1:0]  fifoCount,
  input dpEvt_t                      dpEvt,
  input dpCtrl_t                     dpCtrl,
  input logic                        ovrPend
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] C_DEPTH = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] C_THR   = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] C_ONE   = CNT_W'(1);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifoCount <= C_DEPTH); // R6

  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dpCtrl.popReq && fifoCount != '0 && !dpEvt.pushed) |=> fifoCount == $past(fifoCount) - C_ONE); // R6

  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (dpEvt.dropped && !dpCtrl.popReq) |=> fifoCount == C_DEPTH); // R8

  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    dpEvt.dropped |=> ovrPend); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovrPend && !(regRd && regAddr == OFS_LSTAT)) |=> ovrPend); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (regWr && regAddr == OFS_AUX && regWdata[BIT_AUX_IDLE]) |=> !(dpEvt.pushed || dpEvt.dropped)); // R5

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovrPend || fifoCount >= C_THR)); // R9

endmodule

bind ir_rl_sampler ir_rl_checker #(.DEPTH(FIFO_DEPTH), .THRESH(RX_THRESH)) uChk (
  .clk       (clk),
  .rst_n     (rst_n),
  .regAddr   (regAddr),
  .regWr     (regWr),
  .regRd     (regRd),
  .regWdata  (regWdata),
  .irq       (irq),
  .fifoCount (fifoCount),
  .dpEvt     (dpEvt),
  .dpCtrl    (dpCtrl),
  .ovrPend   (ovrPend)
);

// File: tb/tb_ir_rl_sampler.sv
module tb_ir_rl_sampler;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 8;
  localparam logic [2:0] A_DATA = 3'd0, A_IEN = 3'd1, A_IID = 3'd2, A_LS = 3'd3, A_AUX = 3'd4;

  logic clk, rst_n, irIn, invertEn, regWr, regRd, irq;
  logic [2:0] regAddr;
  logic [7:0] regWdata, regRdata;

  ir_rl_sampler #(.TICK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .irIn(irIn), .invertEn(invertEn),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] expQ[$];
  bit expOvr;
  bit curLvl, started, inv;
  int curTicks;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  function automatic void pushExp(input logic [7:0] b);
    if (expQ.size() >= 16) expOvr = 1'b1;
    else expQ.push_back(b);
  endfunction

  // expected byte stream for a finished run (R1, R2)
  function automatic void emitRun(input bit lvl, input int ticks);
    for (int k = 0; k < (ticks - 1) / 128; k++) pushExp({~lvl, 7'h7F});
    pushExp({~lvl, 7'((ticks - 1) % 128)});
  endfunction

  task automatic hold(input bit lvl, input int n);
    if (lvl != curLvl) begin
      if (started) emitRun(curLvl, curTicks);
      started  = 1'b1;
      curLvl   = lvl;
      curTicks = n;
    end else begin
      curTicks += n;
    end
    irIn = lvl ^ inv;
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic forceIdle();
    regWrite(A_AUX, 8'h20);
    started = 1'b0;
  endtask

  task automatic startSeq(input bit newInv);
    forceIdle();
    inv = newInv;
    invertEn = newInv;
    irIn = curLvl ^ inv;
    hold(curLvl, 2);
  endtask

  task automatic drain(input string req);
    logic [7:0] d;
    while (expQ.size() > 0) begin
      logic [7:0] e;
      e = expQ.pop_front();
      regRead(A_DATA, d);
      chk(d == e, req, d, e);
    end
    regRead(A_LS, d);
    chk(d[0] == 1'b0, "R7 empty after drain", d, 0);
  endtask

  initial begin
    int ticks;
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5EED_1234));
    rst_n = 0; irIn = 0; invertEn = 0; regWr = 0; regRd = 0; regAddr = '0; regWdata = '0;
    curLvl = 0; started = 0; inv = 0; curTicks = 0; expOvr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R10 reset state
    regRead(A_LS, d);   chk(d == 8'h00, "R10 lstat", d, 0);
    regRead(A_IID, d);  chk(d == 8'h00, "R10 iid", d, 0);
    regRead(A_IEN, d);  chk(d == 8'h00, "R10 ien", d, 0);
    chk(irq == 1'b0, "R10 irq", irq, 0);
    regRead(A_DATA, d); chk(d == 8'h00, "R6 empty read", d, 0);

    // R3: steady level produces nothing
    startSeq(0);
    hold(0, 40);
    regRead(A_LS, d); chk(d[0] == 1'b0, "R3 no initial byte", d, 0);

    // R1 basic runs
    startSeq(0);
    hold(1, 5); hold(0, 7); hold(1, 1); hold(0, 3); hold(1, 3);
    forceIdle();
    regRead(A_LS, d); chk(d[0] == 1'b1, "R7 avail set", d, 1);
    drain("R1 basic");

    // R2 boundaries 128 / 129 / 257
    startSeq(0);
    hold(1, 128); hold(0, 129); hold(1, 1); hold(0, 257); hold(1, 3);
    forceIdle();
    drain("R2 split");

    // R4 inverted polarity
    startSeq(1);
    hold(~curLvl, 4); hold(~curLvl, 9); hold(~curLvl, 2); hold(~curLvl, 3);
    forceIdle();
    drain("R4 invert");
    startSeq(0);

    // R5 idle mid-run keeps FIFO, discards run
    startSeq(0);
    hold(~curLvl, 5); hold(~curLvl, 7); hold(~curLvl, 30);
    forceIdle();
    hold(curLvl, 3); hold(~curLvl, 4); hold(~curLvl, 3);
    forceIdle();
    drain("R5 idle");

    // R9 threshold: 7 bytes then 8
    regWrite(A_IEN, 8'h01);
    startSeq(0);
    for (int i = 0; i < 8; i++) hold(~curLvl, 1 + (i % 3));
    forceIdle();
    regRead(A_IID, d); chk(d[0] == 1'b0, "R9 below threshold", d, 0);
    chk(irq == 1'b0, "R9 irq low at 7", irq, 0);
    startSeq(0);
    hold(~curLvl, 2); hold(~curLvl, 3);
    forceIdle();
    regRead(A_IID, d); chk(d[0] == 1'b1, "R9 at threshold", d, 1);
    chk(irq == 1'b1, "R9 irq high at 8", irq, 1);
    begin
      logic [7:0] e;
      e = expQ.pop_front();
      regRead(A_DATA, d); chk(d == e, "R6 oldest first", d, e);
    end
    chk(irq == 1'b0, "R9 irq drops at 7", irq, 0);
    drain("R6 drain");

    // R8 overrun with error interrupt only
    regWrite(A_IEN, 8'h04);
    expOvr = 0;
    startSeq(0);
    for (int i = 0; i < 20; i++) hold(~curLvl, 1 + (i % 2));
    forceIdle();
    chk(expOvr == 1'b1, "R8 bench model overran", expOvr, 1);
    regRead(A_IID, d); chk(d[2] == 1'b1, "R9 iid error bit", d, 8'h04);
    chk(irq == 1'b1, "R9 error irq", irq, 1);
    regRead(A_LS, d);  chk(d == 8'h03, "R8 lstat overrun", d, 8'h03);
    regRead(A_LS, d);  chk(d == 8'h01, "R8 read clears", d, 8'h01);
    chk(irq == 1'b0, "R8 irq cleared", irq, 0);
    drain("R8 contents kept");
    regWrite(A_IEN, 8'h00);

    // random sequences
    for (int s = 0; s < 6; s++) begin
      startSeq(bit'($urandom_range(0, 1)));
      for (int h = 0; h < 5; h++) hold(~curLvl, $urandom_range(1, 260));
      hold(~curLvl, 3);
      forceIdle();
      drain((inv) ? "R4 random" : "R1 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule